// File: doc/BRIEF.md
# Predicated Vector Lane-Merge ALU

This block operates on a 128-bit vector divided into lanes of 8, 16 or 32 bits. The lane width is picked per operation. A single 16-bit predicate, with one bit for each byte position, decides which lanes are active. Each active lane receives either the lane sum of two operand vectors or a copy of a scalar. Each inactive lane is filled according to a fill mode: it copies the same lane from a third vector (merge), becomes zero (zero), or is left unspecified (don't-care). The hardware passes the merge value through in the don't-care case, so the output stays deterministic.

A third operation builds a predicate. Each lane of the first operand is compared, as a signed value, against the scalar truncated to the lane width. Every predicate bit of a lane is set when that lane is greater than or equal to the scalar. If this predicate is fed into a following predicated duplicate of the same scalar, the vector is clamped to an upper bound.

Every operation is accepted on a cycle where the valid input is high. Its result is registered and appears on the next clock edge.

Top module: `pred_lane_alu`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid` is 0, `vec_out` is all zeros and `mask_out` is 0.
- R2: A request accepted with `in_valid` high updates `vec_out` or `mask_out` at the next rising edge, with `out_valid` high for exactly that cycle. When `in_valid` is low, `out_valid` is 0 and both `vec_out` and `mask_out` hold their values.
- R3: Lane-width codes are 0 = 8-bit, 1 = 16-bit, and 2 or 3 = 32-bit. Lane k occupies bits [k*W +: W] and is enabled only by mask bit k*W/8, the lowest byte of the lane. The other mask bits inside a lane have no effect.
- R4: With op code 0 (or 3), an enabled lane receives the sum of its `vec_a` and `vec_b` lanes modulo 2^W. No carry crosses a lane boundary.
- R5: With fill code 0 (merge), a disabled lane takes the same lane of `vec_inact`.
- R6: With fill code 1 (zero), a disabled lane becomes all zeros.
- R7: With fill code 2 or 3 (don't-care), a disabled lane carries the `vec_inact` lane, the same as merge.
- R8: With op code 1 (duplicate), an enabled lane receives the low W bits of `scalar`, and disabled lanes are filled as in R5 to R7.
- R9: With op code 2 (predicate generate), each lane sets all of its W/8 `mask_out` bits when the signed `vec_a` lane is greater than or equal to the signed low W bits of `scalar`, and clears them otherwise. The input mask is not used and `vec_out` is unchanged.
- R10: Op codes 0, 1 and 3 leave `mask_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request accepted this cycle |
| op_sel | input | 2 | 0 add, 1 duplicate, 2 predicate generate, 3 add |
| width_sel | input | 2 | 0 byte, 1 halfword, 2 or 3 word lanes |
| fill_sel | input | 2 | 0 merge, 1 zero, 2 or 3 don't-care |
| mask_in | input | 16 | Per-byte predicate |
| vec_a | input | 128 | First operand |
| vec_b | input | 128 | Second operand |
| vec_inact | input | 128 | Source for disabled lanes |
| scalar | input | 32 | Duplicate value and compare threshold |
| out_valid | output | 1 | Result registered this cycle |
| vec_out | output | 128 | Registered vector result |
| mask_out | output | 16 | Registered generated predicate |

## Verification
Lane-boundary carry suppression and inactive-lane fill act on adjacent bytes in the same cycle. The case that matters is a sum that overflows in an enabled lane sitting directly below a disabled lane. The bench forces 0xFF+0x01 in byte lanes and 0xFFFFFFFF+1 in word lanes, with the upper neighbour masked off under merge fill. It then requires the enabled lane to wrap to zero and the neighbour to equal its inactive value exactly, with no stray carry. Predicate generation followed by a predicated duplicate is also run back to back, and the clamped result is judged against fixed expected words.

// File: rtl/pla_pkg.sv
package pla_pkg;

    typedef enum logic [1:0] {
        LW_8   = 2'd0,
        LW_16  = 2'd1,
        LW_32  = 2'd2,
        LW_32R = 2'd3
    } lane_w_e;

    typedef enum logic [1:0] {
        FILL_MERGE = 2'd0,
        FILL_ZERO  = 2'd1,
        FILL_ANY   = 2'd2,
        FILL_ANY2  = 2'd3
    } fill_e;

    typedef enum logic [1:0] {
        OP_ADD   = 2'd0,
        OP_DUP   = 2'd1,
        OP_CMPGE = 2'd2,
        OP_ADD2  = 2'd3
    } op_e;

endpackage

// File: rtl/pla_lane_en.sv
module pla_lane_en
    import pla_pkg::*;
#(
    parameter int NB = 16
) (
    input  lane_w_e          width,
    input  logic [NB-1:0]    mask,
    output logic [NB-1:0]    byte_en
);
    // Each byte inherits the predicate bit of the lowest byte of its lane.
    for (genvar j = 0; j < NB; j++) begin : gen_en
        localparam int BASE16 = (j / 2) * 2;
        localparam int BASE32 = (j / 4) * 4;
        always_comb begin
            unique case (width)
                LW_8:    byte_en[j] = mask[j];
                LW_16:   byte_en[j] = mask[BASE16];
                default: byte_en[j] = mask[BASE32];
            endcase
        end
    end
endmodule

// File: rtl/pla_lane_add.sv
module pla_lane_add
    import pla_pkg::*;
#(
    parameter int NB = 16,
    localparam int VW = NB * 8
) (
    input  lane_w_e        width,
    input  logic [VW-1:0]  a,
    input  logic [VW-1:0]  b,
    output logic [VW-1:0]  sum
);
    // Byte-sliced adder; the carry into a byte is cut where a lane begins.
    for (genvar j = 0; j < NB; j++) begin : gen_b
        logic cin;
        logic cout;
        logic [8:0] s;

        if (j % 4 == 0) begin : g_c0
            assign cin = 1'b0;
        end else if (j % 2 == 0) begin : g_c16
            assign cin = (width == LW_8 || width == LW_16) ? 1'b0 : gen_b[j-1].cout;
        end else begin : g_codd
            assign cin = (width == LW_8) ? 1'b0 : gen_b[j-1].cout;
        end

        assign s = {1'b0, a[8*j +: 8]} + {1'b0, b[8*j +: 8]} + {8'd0, cin};
        assign sum[8*j +: 8] = s[7:0];

        if (j % 4 != 3) begin : g_co
            assign cout = s[8];
        end else begin : g_nco
            assign cout = 1'b0;
        end
    end
endmodule

// File: rtl/pla_pred_gen.sv
module pla_pred_gen
    import pla_pkg::*;
#(
    parameter int NB = 16,
    parameter int SW = 32,
    localparam int VW = NB * 8
) (
    input  lane_w_e        width,
    input  logic [VW-1:0]  a,
    input  logic [SW-1:0]  scalar,
    output logic [NB-1:0]  pmask
);
    localparam int N16 = NB / 2;
    localparam int N32 = NB / 4;

    logic [NB-1:0]  ge8;
    logic [N16-1:0] ge16;
    logic [N32-1:0] ge32;

    for (genvar k = 0; k < NB; k++) begin : gen_c8
        assign ge8[k] = $signed(a[8*k +: 8]) >= $signed(scalar[7:0]);
    end
    for (genvar k = 0; k < N16; k++) begin : gen_c16
        assign ge16[k] = $signed(a[16*k +: 16]) >= $signed(scalar[15:0]);
    end
    for (genvar k = 0; k < N32; k++) begin : gen_c32
        assign ge32[k] = $signed(a[32*k +: 32]) >= $signed(scalar[31:0]);
    end

    // Replicate each lane verdict over all byte positions of that lane.
    for (genvar j = 0; j < NB; j++) begin : gen_sel
        always_comb begin
            unique case (width)
                LW_8:    pmask[j] = ge8[j];
                LW_16:   pmask[j] = ge16[j/2];
                default: pmask[j] = ge32[j/4];
            endcase
        end
    end
endmodule

// File: rtl/pred_lane_alu.sv
module pred_lane_alu
    import pla_pkg::*;
#(
    parameter int VEC_W = 128,
    parameter int SCAL_W = 32,
    localparam int NB = VEC_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op_sel,
    input  logic [1:0]        width_sel,
    input  logic [1:0]        fill_sel,
    input  logic [NB-1:0]     mask_in,
    input  logic [VEC_W-1:0]  vec_a,
    input  logic [VEC_W-1:0]  vec_b,
    input  logic [VEC_W-1:0]  vec_inact,
    input  logic [SCAL_W-1:0] scalar,
    output logic              out_valid,
    output logic [VEC_W-1:0]  vec_out,
    output logic [NB-1:0]     mask_out
);
    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] vec;
        logic [NB-1:0]    mask;
    } state_t;

    state_t  st_d, st_q;
    lane_w_e width;
    fill_e   fill;
    op_e     op;

    logic [NB-1:0]    byte_en;
    logic [NB-1:0]    pmask;
    logic [VEC_W-1:0] sum_v;
    logic [VEC_W-1:0] dup_v;

    assign width = lane_w_e'(width_sel);
    assign fill  = fill_e'(fill_sel);
    assign op    = op_e'(op_sel);

    pla_lane_en #(.NB(NB)) u_en (
        .width   (width),
        .mask    (mask_in),
        .byte_en (byte_en)
    );

    pla_lane_add #(.NB(NB)) u_add (
        .width (width),
        .a     (vec_a),
        .b     (vec_b),
        .sum   (sum_v)
    );

    pla_pred_gen #(.NB(NB), .SW(SCAL_W)) u_pgen (
        .width  (width),
        .a      (vec_a),
        .scalar (scalar),
        .pmask  (pmask)
    );

    // Scalar broadcast: byte j repeats scalar byte (j mod bytes-per-lane).
    for (genvar j = 0; j < NB; j++) begin : gen_dup
        always_comb begin
            unique case (width)
                LW_8:    dup_v[8*j +: 8] = scalar[7:0];
                LW_16:   dup_v[8*j +: 8] = scalar[8*(j%2) +: 8];
                default: dup_v[8*j +: 8] = scalar[8*(j%4) +: 8];
            endcase
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            if (op == OP_CMPGE) begin
                st_d.mask = pmask;
            end else begin
                for (int j = 0; j < NB; j++) begin
                    if (byte_en[j]) begin
                        st_d.vec[8*j +: 8] = (op == OP_DUP) ? dup_v[8*j +: 8] : sum_v[8*j +: 8];
                    end else if (fill == FILL_ZERO) begin
                        st_d.vec[8*j +: 8] = 8'd0;
                    end else begin
                        st_d.vec[8*j +: 8] = vec_inact[8*j +: 8];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign vec_out   = st_q.vec;
    assign mask_out  = st_q.mask;

    AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(vec_out) && $stable(mask_out))); // R2
    AST_MERGE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel != 2'd2 && fill_sel == 2'd0 && !mask_in[0])
        |=> vec_out[7:0] == $past(vec_inact[7:0])); // R5
    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel != 2'd2 && fill_sel == 2'd1 && !mask_in[0])
        |=> vec_out[7:0] == 8'd0); // R6
    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel != 2'd2) |=> $stable(mask_out)); // R10
    AST_CMP_VEC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'd2) |=> $stable(vec_out)); // R9
    AST_W32_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'd2 && width_sel == 2'd2)
        |=> (mask_out[3:0] == 4'h0 || mask_out[3:0] == 4'hF)); // R9
endmodule

// File: tb/pred_lane_alu_test.sv
`timescale 1ns/1ps
module pred_lane_alu_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   op_sel = '0, width_sel = '0, fill_sel = '0;
    logic [15:0]  mask_in = '0;
    logic [127:0] vec_a = '0, vec_b = '0, vec_inact = '0;
    logic [31:0]  scalar = '0;
    logic         out_valid;
    logic [127:0] vec_out;
    logic [15:0]  mask_out;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [127:0] exp_vec = '0;
    logic [15:0]  exp_mask = '0;

    localparam logic [127:0] PAT = 128'h44444444_33333333_22222222_11111111;

    always #10 clk = ~clk;

    pred_lane_alu uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .width_sel(width_sel), .fill_sel(fill_sel), .mask_in(mask_in),
        .vec_a(vec_a), .vec_b(vec_b), .vec_inact(vec_inact), .scalar(scalar),
        .out_valid(out_valid), .vec_out(vec_out), .mask_out(mask_out)
    );

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Reference from the requirements: lane by lane on whole-vector shifts.
    task automatic model(input logic [1:0] op, input logic [1:0] w, input logic [1:0] fl,
                         input logic [15:0] m, input logic [127:0] a, input logic [127:0] b,
                         input logic [127:0] ia, input logic [31:0] sc);
        int bpl = (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
        int lw = bpl * 8;
        logic [127:0] lm = (128'd1 << lw) - 128'd1;
        logic [127:0] sb = 128'd1 << (lw - 1);
        logic [127:0] nv = '0;
        logic [15:0]  nm = '0;
        for (int k = 0; k < 16 / bpl; k++) begin
            int lo = k * lw;
            logic [127:0] la = (a >> lo) & lm;
            logic [127:0] lb = (b >> lo) & lm;
            logic [127:0] li = (ia >> lo) & lm;
            logic [127:0] ls = {96'd0, sc} & lm;
            logic [127:0] r;
            if (op == 2'd2) begin
                if ((la ^ sb) >= (ls ^ sb)) nm = nm | (16'((1 << bpl) - 1) << (k * bpl));
            end else begin
                if (m[k * bpl]) r = (op == 2'd1) ? ls : ((la + lb) & lm);
                else            r = (fl == 2'd1) ? 128'd0 : li;
                nv = nv | (r << lo);
            end
        end
        if (op == 2'd2) exp_mask = nm;
        else            exp_vec = nv;
    endtask

    task automatic apply(string tag, logic [1:0] op, logic [1:0] w, logic [1:0] fl,
                         logic [15:0] m, logic [127:0] a, logic [127:0] b,
                         logic [127:0] ia, logic [31:0] sc);
        model(op, w, fl, m, a, b, ia, sc);
        @(negedge clk);
        op_sel = op; width_sel = w; fill_sel = fl; mask_in = m;
        vec_a = a; vec_b = b; vec_inact = ia; scalar = sc; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " R2 out_valid"}, {127'd0, out_valid}, 128'd1);
        chk({tag, " vec_out"}, vec_out, exp_vec);
        chk({tag, " mask_out"}, {112'd0, mask_out}, {112'd0, exp_mask});
    endtask

    task automatic t_reset();
        chk("R1 out_valid", {127'd0, out_valid}, 128'd0);
        chk("R1 vec_out", vec_out, 128'd0);
        chk("R1 mask_out", {112'd0, mask_out}, 128'd0);
    endtask

    task automatic t_merge32();
        apply("R5 R4 merge32", 2'd0, 2'd2, 2'd0, 16'hF00F, PAT, PAT, {4{32'h55555555}}, 32'd0);
        chk("R5 merge32 literal", vec_out, 128'h88888888_55555555_55555555_22222222);
    endtask

    task automatic t_zero_fill();
        apply("R6 zero32", 2'd0, 2'd2, 2'd1, 16'h0FF0, PAT, 128'd0, {4{32'hAAAAAAAA}}, 32'd0);
        chk("R6 zero32 literal", vec_out, 128'h00000000_33333333_22222222_00000000);
        apply("R6 R3 zero8", 2'd0, 2'd0, 2'd1, 16'h1111, PAT, 128'd0, {16{8'hEE}}, 32'd0);
        chk("R6 zero8 literal", vec_out, 128'h00000044_00000033_00000022_00000011);
        apply("R3 zero16", 2'd0, 2'd1, 2'd1, 16'h300C, PAT, 128'd0, '1, 32'd0);
        chk("R3 zero16 literal", vec_out, 128'h00004444_00000000_00000000_11110000);
    endtask

    task automatic t_ignored_bits();
        apply("R3 upper lane bits", 2'd0, 2'd2, 2'd0, 16'hEEEE, PAT, PAT, {4{32'h0BADF00D}}, 32'd0);
        chk("R3 upper lane bits literal", vec_out, {4{32'h0BADF00D}});
        apply("R3 width code 3", 2'd0, 2'd3, 2'd0, 16'h0001, PAT, PAT, 128'd0, 32'd0);
        chk("R3 width code 3 literal", vec_out, 128'h22222222);
    endtask

    task automatic t_wrap();
        apply("R4 wrap8", 2'd0, 2'd0, 2'd0, 16'h5555, {16{8'hFF}}, {16{8'h01}}, {16{8'h7E}}, 32'd0);
        chk("R4 wrap8 literal", vec_out, {8{16'h7E00}});
        apply("R4 wrap32", 2'd0, 2'd2, 2'd0, 16'h0101, {4{32'hFFFFFFFF}}, {4{32'h00000001}},
              {4{32'h12345678}}, 32'd0);
        chk("R4 wrap32 literal", vec_out, 128'h12345678_00000000_12345678_00000000);
        apply("R4 wrap16 op3", 2'd3, 2'd1, 2'd1, 16'hFFFF, {8{16'h8001}}, {8{16'hFFFF}}, '0, 32'd0);
    endtask

    task automatic t_clamp();
        apply("R9 clamp gen", 2'd2, 2'd2, 2'd0, 16'h0000, PAT, '0, '0, 32'h30000000);
        chk("R9 clamp mask literal", {112'd0, mask_out}, {112'd0, 16'hFF00});
        apply("R8 clamp dup", 2'd1, 2'd2, 2'd0, mask_out, '0, '0, PAT, 32'h30000000);
        chk("R8 clamp literal", vec_out, 128'h30000000_30000000_22222222_11111111);
    endtask

    task automatic t_signed();
        apply("R9 signed8", 2'd2, 2'd0, 2'd0, 16'hFFFF,
              128'h05_80_7F_04_05_FF_00_06_05_80_7F_04_05_FF_00_06, '0, '0, 32'h00000005);
        chk("R9 signed8 literal", {112'd0, mask_out}, {112'd0, 16'hA9A9});
        apply("R9 signed16", 2'd2, 2'd1, 2'd0, 16'h0000,
              {4{16'hFFFE, 16'h0001}}, '0, '0, 32'h0000FFFF);
        chk("R9 signed16 literal", {112'd0, mask_out}, {112'd0, 16'h3333});
        apply("R8 dup16 zero", 2'd1, 2'd1, 2'd1, 16'h000C, '0, '0, '1, 32'hDEADBEEF);
        chk("R8 dup16 literal", vec_out, 128'h0000_0000_0000_0000_0000_0000_BEEF_0000);
    endtask

    task automatic t_dontcare();
        apply("R7 dontcare", 2'd0, 2'd2, 2'd2, 16'h000F, PAT, PAT, {4{32'hCAFEF00D}}, 32'd0);
        apply("R7 dontcare code 3", 2'd1, 2'd0, 2'd3, 16'h00FF, '0, '0, {16{8'h3C}}, 32'h000000A5);
        chk("R7 dontcare literal", vec_out, {{8{8'h3C}}, {8{8'hA5}}});
    endtask

    task automatic t_hold();
        logic [127:0] v;
        logic [15:0]  m;
        v = vec_out; m = mask_out;
        @(negedge clk);
        op_sel = 2'd2; vec_a = '1; scalar = '0; mask_in = 16'hFFFF; fill_sel = 2'd1;
        @(negedge clk);
        @(negedge clk);
        chk("R2 idle valid", {127'd0, out_valid}, 128'd0);
        chk("R2 idle vec", vec_out, v);
        chk("R2 idle mask", {112'd0, mask_out}, {112'd0, m});
    endtask

    task automatic t_mask_keep();
        apply("R9 set mask", 2'd2, 2'd2, 2'd0, 16'h0, 128'h00000001_80000000_00000005_00000000, '0, '0, 32'd1);
        chk("R9 set mask literal", {112'd0, mask_out}, {112'd0, 16'hF0F0});
        apply("R10 add keeps mask", 2'd0, 2'd1, 2'd0, 16'hFFFF, PAT, PAT, '0, 32'd0);
        chk("R10 mask after add", {112'd0, mask_out}, {112'd0, 16'hF0F0});
        apply("R10 dup keeps mask", 2'd1, 2'd0, 2'd1, 16'h0000, '0, '0, '0, 32'd7);
        chk("R10 mask after dup", {112'd0, mask_out}, {112'd0, 16'hF0F0});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_merge32();
        t_zero_fill();
        t_ignored_bits();
        t_wrap();
        t_clamp();
        t_signed();
        t_dontcare();
        t_hold();
        t_mask_keep();
        summary();
    end
endmodule